// File: doc/BRIEF.md
# DMA Channel Status and Start Gate

This block keeps the event status of one DMA channel and decides whether a software start request may launch a transfer. The transfer engine reports normal completion, a bus error on the read side, a bus error on the write side and breakpoint hits. Each report sets a sticky flag, and each flag stays set until software writes a one to its position. The five flags are ORed into a summary interrupt bit. That bit sits in the top position of the status byte, so a signed test of the byte shows whether anything is pending.

Software programs a source address, a destination address, a byte count and the two port sizes, then writes the start bit. The start write has no effect while any flag is pending. Otherwise the block checks the programmed values against the port sizes. If the check fails, it raises a configuration-error flag in place of a launch. If the check passes, it sends a single-cycle launch pulse to the engine and holds the channel in the running state until completion or a bus error ends it.

Top module: `dma_stat_ctrl`

## Requirements
- R1: After reset the status byte (address 0) reads 0x00, the control word (address 1) reads 0, `run_o` is 0 and `launch_o` is 0.
- R2: While running, the engine inputs set status bits one cycle after they are asserted. `done_i` sets bit 6, `rd_err_i` sets bit 5 and `wr_err_i` sets bit 4. Any of these three also clears the running state, so control bit 0 and `run_o` drop to 0.
- R3: Status bit 7 is 1 exactly when at least one of bits 6..2 is 1, so the status byte reads negative as a signed value whenever an event is pending.
- R4: A status write clears each flag whose data bit is 1 and leaves unchanged each flag whose data bit is 0. Bits 1..0 always read 0.
- R5: A status write of 0x7C clears all five flags in one write.
- R6: A control write with bit 0 set is ignored while status bit 7 is 1: no launch, and control bit 0 stays 0.
- R7: A start write raises status bit 3 instead of launching, and control bit 0 stays 0, in any of these cases:
  - the word source port (control bit 1) is chosen and the source address is odd;
  - the word destination port (control bit 2) is chosen and the destination address is odd;
  - the byte count is zero;
  - either port is word-sized and the count is odd.
- R8: A start write that passes the checks gives `launch_o` high for exactly the one cycle after the write. From then on control bit 0 and `run_o` read 1.
- R9: `brk_i` sets status bit 2 while running, and the channel keeps running.
- R10: When a hardware set and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R11: Engine event inputs and `brk_i` have no effect while the channel is not running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index: 0 status, 1 control, 2 source, 3 destination, 4 count |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| done_i | input | 1 | Engine: normal termination |
| rd_err_i | input | 1 | Engine: bus error on a read cycle |
| wr_err_i | input | 1 | Engine: bus error on a write cycle |
| brk_i | input | 1 | Breakpoint signal |
| launch_o | output | 1 | One-cycle pulse telling the engine to begin |
| run_o | output | 1 | Channel is running |

## Verification
Two things can touch the same flag in one cycle: a hardware event setting it and a software write-one-to-clear. The bench forces this overlap by raising `brk_i` in the same cycle as a status write of 0x04 while the breakpoint flag is already set. It passes if the flag is still set afterwards, and a later write with no event pending must then clear it. A second overlap is a start write while a flag is pending. There the bench checks that the start is dropped rather than queued.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  localparam int unsigned NUM_FLAGS = 5;
  // flag index = status bit - 2
  localparam int unsigned F_BRK  = 0;
  localparam int unsigned F_CFG  = 1;
  localparam int unsigned F_WERR = 2;
  localparam int unsigned F_RERR = 3;
  localparam int unsigned F_DONE = 4;
  localparam int unsigned FLAG_LSB = 2;

  typedef enum logic [2:0] {
    RA_STAT = 3'd0,
    RA_CTRL = 3'd1,
    RA_SRC  = 3'd2,
    RA_DST  = 3'd3,
    RA_CNT  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/dma_flag_bank.sv
module dma_flag_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flags_o[g] <= 1'b0;
      else if (set_i[g])  flags_o[g] <= 1'b1;  // set beats clear
      else if (clr_i[g])  flags_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_cfg_check.sv
module dma_cfg_check #(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] cnt_i,
  input  logic          src_word_i,
  input  logic          dst_word_i,
  output logic          bad_o
);
  logic any_word;
  always_comb begin
    any_word = src_word_i | dst_word_i;
    bad_o = (src_word_i & src_i[0]) |
            (dst_word_i & dst_i[0]) |
            (cnt_i == '0) |
            (any_word & cnt_i[0]);
  end
endmodule

// File: rtl/dma_stat_ctrl.sv
module dma_stat_ctrl
  import dma_stat_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          done_i,
  input  logic          rd_err_i,
  input  logic          wr_err_i,
  input  logic          brk_i,
  output logic          launch_o,
  output logic          run_o
);
  localparam int unsigned NF = NUM_FLAGS;

  logic [DW-1:0] src_q, dst_q, cnt_q;
  logic          src_word_q, dst_word_q;
  logic          run_q, launch_q;
  logic [NF-1:0] flags_w, set_w, clr_w;
  logic [7:0]    stat_w;
  logic          irq_w, cfg_bad_w, start_try_w, start_ok_w, term_w;
  logic          we_stat, we_ctrl;

  always_comb begin
    we_stat     = reg_we_i && (reg_addr_i == RA_STAT);
    we_ctrl     = reg_we_i && (reg_addr_i == RA_CTRL);
    irq_w       = |flags_w;
    stat_w      = {irq_w, flags_w, 2'b00};
    start_try_w = we_ctrl && reg_wdata_i[0] && !irq_w && !run_q;
    start_ok_w  = start_try_w && !cfg_bad_w;
    term_w      = run_q && (done_i || rd_err_i || wr_err_i);
  end

  dma_cfg_check #(.AW(DW)) u_chk_cfg (
    .src_i      (src_q),
    .dst_i      (dst_q),
    .cnt_i      (cnt_q),
    .src_word_i (reg_wdata_i[1]),
    .dst_word_i (reg_wdata_i[2]),
    .bad_o      (cfg_bad_w)
  );

  always_comb begin
    set_w         = '0;
    set_w[F_DONE] = run_q && done_i;
    set_w[F_RERR] = run_q && rd_err_i;
    set_w[F_WERR] = run_q && wr_err_i;
    set_w[F_BRK]  = run_q && brk_i;
    set_w[F_CFG]  = start_try_w && cfg_bad_w;
    clr_w         = we_stat ? reg_wdata_i[FLAG_LSB +: NF] : '0;
  end

  dma_flag_bank #(.N(NF)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_w),
    .clr_i   (clr_w),
    .flags_o (flags_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q      <= '0;
      dst_q      <= '0;
      cnt_q      <= '0;
      src_word_q <= 1'b0;
      dst_word_q <= 1'b0;
      run_q      <= 1'b0;
      launch_q   <= 1'b0;
    end else begin
      if (reg_we_i && reg_addr_i == RA_SRC) src_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == RA_DST) dst_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == RA_CNT) cnt_q <= reg_wdata_i;
      if (we_ctrl) begin
        src_word_q <= reg_wdata_i[1];
        dst_word_q <= reg_wdata_i[2];
      end
      launch_q <= start_ok_w;
      if (start_ok_w)  run_q <= 1'b1;
      else if (term_w) run_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_STAT: reg_rdata_o[7:0] = stat_w;
      RA_CTRL: reg_rdata_o[2:0] = {dst_word_q, src_word_q, run_q};
      RA_SRC:  reg_rdata_o = src_q;
      RA_DST:  reg_rdata_o = dst_q;
      RA_CNT:  reg_rdata_o = cnt_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assign launch_o = launch_q;
  assign run_o    = run_q;
endmodule

// File: rtl/dma_stat_ctrl_chk.sv
module dma_stat_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       launch_o,
  input logic       run_o,
  input logic [4:0] flags,
  input logic       done_i,
  input logic       rd_err_i,
  input logic       wr_err_i,
  input logic       brk_i
);
  AST_LAUNCH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> !launch_o); // R8
  AST_LAUNCH_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |-> ($past(flags) == 5'b0)); // R6
  AST_CFG_NO_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[1]) |-> !launch_o); // R7
  AST_RUN_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && (done_i || rd_err_i || wr_err_i)) |=> !run_o); // R2
  AST_DONE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && done_i) |=> flags[4]); // R10
  AST_IDLE_BRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && brk_i && !flags[0]) |=> !flags[0]); // R11
endmodule

bind dma_stat_ctrl dma_stat_ctrl_chk u_sva (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .launch_o (launch_o),
  .run_o    (run_o),
  .flags    (flags_w),
  .done_i   (done_i),
  .rd_err_i (rd_err_i),
  .wr_err_i (wr_err_i),
  .brk_i    (brk_i)
);

// File: tb/dma_stat_ctrl_tb_top.sv
module dma_stat_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        done_i = 1'b0, rd_err_i = 1'b0, wr_err_i = 1'b0, brk_i = 1'b0;
  logic        launch_o, run_o;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_stat_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .done_i(done_i),
    .rd_err_i(rd_err_i), .wr_err_i(wr_err_i), .brk_i(brk_i),
    .launch_o(launch_o), .run_o(run_o)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic pulse(logic dn, logic re, logic we, logic bk);
    @(negedge clk_i);
    done_i = dn; rd_err_i = re; wr_err_i = we; brk_i = bk;
    @(negedge clk_i);
    done_i = 0; rd_err_i = 0; wr_err_i = 0; brk_i = 0;
  endtask

  task automatic setup(logic [15:0] s, logic [15:0] d, logic [15:0] c);
    wr(3'd2, s); wr(3'd3, d); wr(3'd4, c);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(3'd0, v); chk("R1 status", v, 16'h0000);
    rd(3'd1, v); chk("R1 ctrl", v, 16'h0000);
    chk("R1 run", {15'b0, run_o}, 16'h0);
    chk("R1 launch", {15'b0, launch_o}, 16'h0);
  endtask

  task automatic t_good_start_done();
    logic [15:0] v;
    setup(16'h0100, 16'h0200, 16'h0004);
    wr(3'd1, 16'h0007);
    chk("R8 launch high", {15'b0, launch_o}, 16'h1);
    rd(3'd1, v); chk("R8 ctrl start", v, 16'h0007);
    @(negedge clk_i);
    chk("R8 launch one cycle", {15'b0, launch_o}, 16'h0);
    chk("R8 run", {15'b0, run_o}, 16'h1);
    pulse(1, 0, 0, 0);
    rd(3'd0, v); chk("R2 done bit", v, 16'h00C0);
    chk("R3 negative", {15'b0, $signed(v[7:0]) < 0}, 16'h1);
    chk("R2 run ends", {15'b0, run_o}, 16'h0);
  endtask

  task automatic t_blocked_start();
    logic [15:0] v;
    wr(3'd1, 16'h0001);
    chk("R6 no launch", {15'b0, launch_o}, 16'h0);
    rd(3'd1, v); chk("R6 start stays 0", v, 16'h0000);
    rd(3'd0, v); chk("R6 status kept", v, 16'h00C0);
    wr(3'd0, 16'h007C);
    rd(3'd0, v); chk("R5 all cleared", v, 16'h0000);
  endtask

  task automatic t_w1c_mix();
    logic [15:0] v;
    wr(3'd1, 16'h0001);
    chk("R8 byte launch", {15'b0, launch_o}, 16'h1);
    pulse(0, 0, 0, 1);
    chk("R9 still running", {15'b0, run_o}, 16'h1);
    rd(3'd0, v); chk("R9 brk bit", v, 16'h0084);
    pulse(0, 1, 0, 0);
    rd(3'd0, v); chk("R2 rd err bit", v, 16'h00A4);
    wr(3'd0, 16'h0000);
    rd(3'd0, v); chk("R4 zero write", v, 16'h00A4);
    wr(3'd0, 16'h0020);
    rd(3'd0, v); chk("R4 partial clear", v, 16'h0084);
    wr(3'd0, 16'h0004);
    rd(3'd0, v); chk("R3 irq drops", v, 16'h0000);
  endtask

  task automatic t_collision();
    logic [15:0] v;
    wr(3'd1, 16'h0001);
    pulse(0, 0, 0, 1);
    @(negedge clk_i);
    reg_we_i = 1; reg_addr_i = 3'd0; reg_wdata_i = 16'h0004; brk_i = 1;
    @(negedge clk_i);
    reg_we_i = 0; brk_i = 0;
    rd(3'd0, v); chk("R10 set wins", v, 16'h0084);
    wr(3'd0, 16'h0004);
    rd(3'd0, v); chk("R10 later clear", v, 16'h0000);
    pulse(0, 0, 1, 0);
    rd(3'd0, v); chk("R2 wr err bit", v, 16'h0090);
    wr(3'd0, 16'h00FF);
    rd(3'd0, v); chk("R4 reserved zero", v, 16'h0000);
  endtask

  task automatic t_cfg_errors();
    logic [15:0] v;
    setup(16'h0101, 16'h0200, 16'h0004);
    wr(3'd1, 16'h0003);
    chk("R7 odd src no launch", {15'b0, launch_o}, 16'h0);
    rd(3'd0, v); chk("R7 odd src conf", v, 16'h0088);
    rd(3'd1, v); chk("R7 start cleared", v & 16'h1, 16'h0000);
    wr(3'd0, 16'h007C);
    setup(16'h0100, 16'h0201, 16'h0004);
    wr(3'd1, 16'h0005);
    rd(3'd0, v); chk("R7 odd dst conf", v, 16'h0088);
    wr(3'd0, 16'h0008);
    setup(16'h0100, 16'h0200, 16'h0000);
    wr(3'd1, 16'h0001);
    rd(3'd0, v); chk("R7 zero count", v, 16'h0088);
    wr(3'd0, 16'h0008);
    setup(16'h0100, 16'h0200, 16'h0003);
    wr(3'd1, 16'h0005);
    rd(3'd0, v); chk("R7 odd count word", v, 16'h0088);
    wr(3'd0, 16'h0008);
    setup(16'h0101, 16'h0203, 16'h0003);
    wr(3'd1, 16'h0001);
    chk("R7 byte odd ok", {15'b0, launch_o}, 16'h1);
    pulse(1, 0, 0, 0);
    wr(3'd0, 16'h007C);
  endtask

  task automatic t_idle_events();
    logic [15:0] v;
    pulse(1, 1, 1, 1);
    rd(3'd0, v); chk("R11 idle events", v, 16'h0000);
    chk("R11 idle run", {15'b0, run_o}, 16'h0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_good_start_done();
    t_blocked_start();
    t_w1c_mix();
    t_collision();
    t_cfg_errors();
    t_idle_events();
    finish_run();
  end
endmodule